// File: doc/BRIEF.md
# Filtered Event Status Register

This block keeps one level of an instrument's status reporting tree. A live 15-bit status vector comes in from hardware, or from the summary bits of lower-level blocks. Each bit can be set to record a rising edge, a falling edge, both edges or neither. Recorded edges stay in a sticky event part until software reads that part. A per-bit enable mask then chooses which sticky bits count toward one summary output, and that output drives a condition input of the next level up.

Software reaches the five 16-bit parts through a plain register port. The port has an address, a write strobe, write data, a read strobe and combinational read data. There is no valid/ready handshake: every access completes in the cycle its strobe is high, and the block never applies back-pressure. A mode pin switches the event part to direct capture. In that mode an asserted status input sets its event bit without edge detection.

Top module: `stat_reg_top`

## Requirements
- R1: Every part is 16 bits wide, and bit n of every part belongs to status input n. Bit 15 always reads 0 and ignores writes. The address map is 0 condition, 1 rising filter, 2 falling filter, 3 event, 4 enable, and any other address reads 0. `rd_data` shows the addressed part in the same cycle, without waiting for a clock edge.
- R2: The condition part (address 0) reads the live `status_in`. Writes to it have no effect, and reading it does not change it.
- R3: When `direct_mode` is low and a status bit goes 0→1 between two clock edges, the matching event bit is set at the second edge if its rising-filter bit is 1.
- R4: When `direct_mode` is low and a status bit goes 1→0, the matching event bit is set if its falling-filter bit is 1. With both filter bits set, either edge latches.
- R5: An edge whose filter bit is 0 sets nothing. A status bit that does not change sets nothing.
- R6: The rising filter, the falling filter and the enable part can be written and read back. Reading them has no side effect.
- R7: A read of the event part (address 3) returns its contents and clears it at that clock edge. Writes to the event part are ignored.
- R8: If an event bit is set in the same cycle that the event part is read, the bit is 1 after that edge.
- R9: `summary` is the OR over all bits of (event AND enable), registered. It follows a change of event or enable one clock later.
- R10: While `direct_mode` is high, each high status input sets its event bit at the next edge, with no edge detection or filtering. Reads still clear the event part.
- R11: After reset the event part is 0, the enable part is 0, the rising filter is 0x7FFF, the falling filter is 0 and `summary` is 0.
- R12: Reset captures the current status as the previous value, so a status that is already high during reset records no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| direct_mode | input | 1 | 1: status inputs set event bits directly |
| status_in | input | 15 | Live status vector |
| reg_addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (clears event on address 3) |
| rd_data | output | 16 | Read data for the addressed part |
| summary | output | 1 | Registered summary bit |

## Verification
The assertions check several behaviours on every cycle:
- Filtered rising and falling edges reach the event part.
- An event bit can only be set by a set request.
- An event read clears the part, and a set in the same cycle wins over that clear.
- Direct mode captures every asserted input.
- The summary follows event AND enable one cycle later.
- An enable write lands with bit 15 dropped.

Only the bench scenarios can show the remaining behaviours:
- The reset values of each part.
- That an input held high through reset records nothing.
- That the condition part ignores writes.
- Edge cases of the filter masks, covered with vectors that mix both edge directions.

// File: rtl/stat_reg_pkg.sv
package stat_reg_pkg;
  localparam int unsigned SW = 15;
  localparam int unsigned DW = SW + 1;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    A_COND = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_EVT  = 3'd3,
    A_ENA  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/stat_edge_detect.sv
module stat_edge_detect #(
  parameter int unsigned SW = 15
) (
  input  logic          clk,
  input  logic          direct_mode,
  input  logic [SW-1:0] status_in,
  input  logic [SW-1:0] rise_mask,
  input  logic [SW-1:0] fall_mask,
  output logic [SW-1:0] set_vec
);
  // Previous status sample. It also loads during reset, so release never sees a false edge.
  logic [SW-1:0] prev_q;
  logic [SW-1:0] rise, fall;

  always_ff @(posedge clk) prev_q <= status_in;

  always_comb begin
    rise = status_in & ~prev_q;
    fall = prev_q & ~status_in;
    if (direct_mode) set_vec = status_in;
    else             set_vec = (rise & rise_mask) | (fall & fall_mask);
  end
endmodule

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
  parameter int unsigned SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          rd_clr,
  output logic [SW-1:0] evt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      evt_q <= '0;
    else if (rd_clr) evt_q <= set_vec;          // clear, but a new set wins
    else             evt_q <= evt_q | set_vec;
  end

  a_r5_only_from_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(set_vec)) == '0));
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((evt_q & ~$past(set_vec)) == '0));
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/stat_summary.sv
module stat_summary #(
  parameter int unsigned SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] evt,
  input  logic [SW-1:0] ena,
  output logic          summary
);
  always_ff @(posedge clk) begin
    if (!rst_n) summary <= 1'b0;
    else        summary <= |(evt & ena);
  end

  a_r9_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary == $past(|(evt & ena))));
endmodule

// File: rtl/stat_reg_top.sv
module stat_reg_top
  import stat_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          direct_mode,
  input  logic [SW-1:0] status_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          summary
);
  localparam logic [SW-1:0] RISE_RST = {SW{1'b1}};
  localparam logic [DW-1:0] MSB_CLR  = {1'b0, {SW{1'b1}}};

  logic [SW-1:0] rise_q, fall_q, ena_q, evt_q, set_vec;
  logic          rd_clr;

  assign rd_clr = rd_en && (reg_addr == A_EVT);

  // Configuration parts; the top data bit is dropped on write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= RISE_RST;
      fall_q <= '0;
      ena_q  <= '0;
    end else if (wr_en) begin
      case (reg_addr)
        A_RISE:  rise_q <= wr_data[SW-1:0];
        A_FALL:  fall_q <= wr_data[SW-1:0];
        A_ENA:   ena_q  <= wr_data[SW-1:0];
        default: ;
      endcase
    end
  end

  stat_edge_detect #(.SW(SW)) edge_i (
    .clk(clk), .direct_mode(direct_mode), .status_in(status_in),
    .rise_mask(rise_q), .fall_mask(fall_q), .set_vec(set_vec));

  stat_event_latch #(.SW(SW)) evt_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_clr), .evt_q(evt_q));

  stat_summary #(.SW(SW)) sum_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_q), .ena(ena_q), .summary(summary));

  always_comb begin
    case (reg_addr)
      A_COND:  rd_data = {1'b0, status_in};
      A_RISE:  rd_data = {1'b0, rise_q};
      A_FALL:  rd_data = {1'b0, fall_q};
      A_EVT:   rd_data = {1'b0, evt_q};
      A_ENA:   rd_data = {1'b0, ena_q};
      default: rd_data = '0;
    endcase
  end

  // Checker-side copy of the previous status, independent of the edge detector
  logic [SW-1:0] prev_chk;
  always_ff @(posedge clk) prev_chk <= status_in;

  a_r3_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |=> ((evt_q & $past(status_in & ~prev_chk & rise_q))
                      == $past(status_in & ~prev_chk & rise_q)));
  a_r4_fall_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |=> ((evt_q & $past(prev_chk & ~status_in & fall_q))
                      == $past(prev_chk & ~status_in & fall_q)));
  a_r10_direct_capture: assert property (@(posedge clk) disable iff (!rst_n)
    direct_mode |=> ((evt_q & $past(status_in)) == $past(status_in)));
  a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_ENA) |=> ({1'b0, ena_q} == ($past(wr_data) & MSB_CLR)));
endmodule

// File: tb/stat_reg_top_tb_top.sv
`timescale 1ns/1ps
module stat_reg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        direct_mode = 1'b0;
  logic [14:0] status_in = '0;
  logic [2:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        summary;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  stat_reg_top dut_i (.*);

  // {rise filter, fall filter, old status, new status, expected event}
  localparam logic [79:0] VEC [8] = '{
    {16'h7FFF, 16'h0000, 16'h0000, 16'h0005, 16'h0005},
    {16'h0000, 16'h7FFF, 16'h0000, 16'h0005, 16'h0000},
    {16'h0000, 16'h7FFF, 16'h00F0, 16'h0030, 16'h00C0},
    {16'h7FFF, 16'h0000, 16'h00F0, 16'h0030, 16'h0000},
    {16'h00FF, 16'hFF00, 16'h0F0F, 16'h70F0, 16'h0FF0},
    {16'h7FFF, 16'h7FFF, 16'h1234, 16'h4321, 16'h5115},
    {16'h0000, 16'h0000, 16'h0000, 16'h7FFF, 16'h0000},
    {16'hFFFF, 16'h0000, 16'h0000, 16'h7FFF, 16'h7FFF}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    // R12 / R11: status high during reset must not record an event
    status_in = 15'h0055;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R11 summary reset", {15'b0, summary}, 16'h0);
    rd(3'd1, v); check("R11 rise filter reset", v, 16'h7FFF);
    rd(3'd2, v); check("R11 fall filter reset", v, 16'h0000);
    rd(3'd4, v); check("R11 enable reset", v, 16'h0000);
    rd(3'd3, v); check("R12 no event from reset", v, 16'h0000);

    // R2: condition tracks status, ignores writes, reads nondestructively
    wr(3'd0, 16'h1111);
    rd(3'd0, v); check("R2 condition live", v, 16'h0055);
    rd(3'd0, v); check("R2 condition reread", v, 16'h0055);
    rd(3'd5, v); check("R1 unmapped address", v, 16'h0000);

    // R3/R4/R5/R1: vector table
    foreach (VEC[i]) begin
      wr(3'd1, VEC[i][79:64]);
      wr(3'd2, VEC[i][63:48]);
      status_in = VEC[i][46:32];
      tick(); tick();
      rd(3'd3, v);                      // flush old events
      status_in = VEC[i][30:16];
      tick();
      rd(3'd3, v);
      check($sformatf("R3 R4 R5 vector %0d", i), v, VEC[i][15:0]);
    end
    rd(3'd3, v); check("R7 event cleared by read", v, 16'h0000);

    // R6 / R1: write and read back, bit 15 dropped
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); check("R1 R6 enable bit15 dropped", v, 16'h7FFF);
    rd(3'd4, v); check("R6 enable reread", v, 16'h7FFF);
    wr(3'd2, 16'h2A5A);
    rd(3'd2, v); check("R6 fall filter write", v, 16'h2A5A);
    wr(3'd4, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h7FFF);

    // R9: summary
    status_in = 15'h0000; tick(); tick();
    rd(3'd3, v);
    status_in = 15'h0008; tick(); tick();
    check("R9 summary masked", {15'b0, summary}, 16'h0);
    wr(3'd3, 16'h0000);                 // R7 write to event ignored
    wr(3'd4, 16'h0008);
    check("R9 summary not before edge", {15'b0, summary}, 16'h0);
    tick();
    check("R9 summary set", {15'b0, summary}, 16'h1);
    rd(3'd3, v); check("R7 event write ignored", v, 16'h0008);
    tick();
    check("R9 summary cleared", {15'b0, summary}, 16'h0);
    wr(3'd4, 16'h0000);

    // R8: set in same cycle as read wins
    status_in = 15'h0000; tick(); tick();
    rd(3'd3, v);
    status_in = 15'h0001;
    rd(3'd3, v); check("R8 read before set", v, 16'h0000);
    rd(3'd3, v); check("R8 set survives clear", v, 16'h0001);

    // R10: direct mode
    wr(3'd1, 16'h0000);
    status_in = 15'h0100;
    direct_mode = 1'b1;
    tick();
    rd(3'd3, v); check("R10 direct set", v, 16'h0100);
    rd(3'd3, v); check("R10 level re-sets", v, 16'h0100);
    status_in = 15'h0000;
    rd(3'd3, v); check("R10 last capture", v, 16'h0100);
    rd(3'd3, v); check("R10 clear on read", v, 16'h0000);
    direct_mode = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule